// File: doc/BRIEF.md
# Eight-Pin Port Interrupt Detector

This block watches the eight input pins of a general-purpose port and turns their activity into one interrupt request. Each pin is brought into the local clock domain by a two-stage synchronizer. It is then judged against its own configuration. A pin can be level-sensitive: it reports while the pin sits at a chosen level. A pin can also be edge-sensitive: it remembers a rising edge, a falling edge or any change until software acknowledges it.

Software uses a small register port with a 3-bit address, a write strobe and a combinational read path. The register map is:

| Address | Contents |
|---|---|
| 0 | Sense selection |
| 1 | Both-edge selection |
| 2 | Polarity |
| 3 | Enable mask |
| 4 | Raw status, read-only |
| 5 | Masked status, read-only |
| 6 | Acknowledge, write-one-to-clear, reads as zero |
| 7 | Synchronized pin levels, read-only |

The parameter `CONN_MASK` marks which pins are wired to a pad. Bits that are not connected behave as if they were absent.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads zero. This means all pins are edge-sensitive, single-edge and falling/low, and fully masked. `irq` is low.
- R2: A pin change driven before clock edge 1 appears in the level register (address 7) after edge 2. In edge mode it sets raw status at edge 3, and not earlier.
- R3: With sense bit = 0 and both-edge bit = 0, polarity bit 1 latches on a rising edge only, and polarity bit 0 latches on a falling edge only.
- R4: With both-edge bit = 1, the pin latches on rising and falling edges whatever its polarity bit holds.
- R5: A latched edge bit stays set until software writes 1 to that bit at address 6. If a new edge arrives in the same cycle as that write, the bit remains set.
- R6: With sense bit = 1, the raw bit equals 1 exactly when the synchronized pin equals the polarity bit (1 = high, 0 = low). The bit is never latched, and writes to address 6 do not affect it.
- R7: Masked status (address 5) is raw status AND the mask (address 3). A mask bit of 1 passes the pin. `irq` is high exactly when any masked bit is 1.
- R8: A write that changes a pin's sense, both-edge or polarity bit clears that pin's pending edge status. Other pins keep theirs.
- R9: For pins outside `CONN_MASK` (default 8'h7F, so pin 7 is absent), writes are ignored. Every register reads 0 in those bits, and the pin never raises status or `irq`.
- R10: Configuration registers 0 to 3 read back what was written in the connected bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_in | input | 8 | Asynchronous port pins |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that a pin is stable for at least two clocks around each change the design is meant to see. They also assume that the bus only writes while the reset is released. The bench moves pins only on falling clock edges and holds each level for several cycles, so every change passes cleanly through the synchronizer. Writes and clears are placed on exact cycles against pin changes to reach the edge-versus-acknowledge collision, and each scenario starts from a fresh reset so that no status carries over between them.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned PORT_W = 8;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_SENSE = 3'd0,
    REG_BOTH  = 3'd1,
    REG_POL   = 3'd2,
    REG_MASK  = 3'd3,
    REG_RAW   = 3'd4,
    REG_MIS   = 3'd5,
    REG_ACK   = 3'd6,
    REG_LVL   = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic [PORT_W-1:0] sense;
    logic [PORT_W-1:0] both;
    logic [PORT_W-1:0] pol;
    logic [PORT_W-1:0] mask;
  } port_cfg_t;

endpackage

// File: rtl/gpio_irq_rst_sync.sv
module gpio_irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = async_i;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d[s];
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic sense_i,
  input  logic both_i,
  input  logic pol_i,
  input  logic sync_i,
  input  logic ack_i,
  input  logic chg_i,
  output logic raw_o
);

  logic prev_q;
  logic edge_q, edge_d;
  logic rise, fall, hit;

  always_comb begin
    rise = sync_i & ~prev_q;
    fall = ~sync_i & prev_q;
    if (both_i) hit = rise | fall;
    else        hit = pol_i ? rise : fall;
    hit = hit & ~sense_i;
  end

  always_comb begin
    edge_d = edge_q;
    if (sense_i)            edge_d = 1'b0;
    else if (hit)           edge_d = 1'b1;
    else if (ack_i | chg_i) edge_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      prev_q <= sync_i;
      edge_q <= edge_d;
    end
  end

  assign raw_o = sense_i ? (sync_i == pol_i) : edge_q;

  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!sense_i && edge_q && !ack_i && !chg_i) |=> edge_q); // R5

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sense_i && !hit && ack_i) |=> !edge_q); // R5

  AST_RISE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (!sense_i && !both_i && pol_i && sync_i && !prev_q) |=> edge_q); // R3

  AST_BOTH_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!sense_i && both_i && !sync_i && prev_q) |=> edge_q); // R4

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter logic [PORT_W-1:0] CONN_MASK = 8'h7F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic [PORT_W-1:0] raw_i,
  input  logic [PORT_W-1:0] lvl_i,
  output port_cfg_t         cfg_o,
  output logic [PORT_W-1:0] ack_o,
  output logic [PORT_W-1:0] chg_o
);

  port_cfg_t         cfg_q, cfg_d;
  logic [PORT_W-1:0] wdata_c;
  logic              cfg_en;

  assign wdata_c = bus_wdata & CONN_MASK;

  always_comb begin
    cfg_d  = cfg_q;
    cfg_en = 1'b0;
    ack_o  = '0;
    if (bus_wr) begin
      case (reg_addr_e'(bus_addr))
        REG_SENSE: begin cfg_d.sense = wdata_c; cfg_en = 1'b1; end
        REG_BOTH:  begin cfg_d.both  = wdata_c; cfg_en = 1'b1; end
        REG_POL:   begin cfg_d.pol   = wdata_c; cfg_en = 1'b1; end
        REG_MASK:  begin cfg_d.mask  = wdata_c; cfg_en = 1'b1; end
        REG_ACK:   ack_o = wdata_c;
        default:   ;
      endcase
    end
    chg_o = (cfg_d.sense ^ cfg_q.sense) | (cfg_d.both ^ cfg_q.both) |
            (cfg_d.pol ^ cfg_q.pol);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  always_comb begin
    case (reg_addr_e'(bus_addr))
      REG_SENSE: bus_rdata = cfg_q.sense;
      REG_BOTH:  bus_rdata = cfg_q.both;
      REG_POL:   bus_rdata = cfg_q.pol;
      REG_MASK:  bus_rdata = cfg_q.mask;
      REG_RAW:   bus_rdata = raw_i & CONN_MASK;
      REG_MIS:   bus_rdata = raw_i & cfg_q.mask & CONN_MASK;
      REG_LVL:   bus_rdata = lvl_i & CONN_MASK;
      default:   bus_rdata = '0;
    endcase
  end

  assign cfg_o = cfg_q;

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == REG_MASK) |=> (cfg_q.mask == (CONN_MASK & $past(bus_wdata)))); // R10

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter logic [PORT_W-1:0] CONN_MASK   = 8'h7F,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter int unsigned       RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic [PORT_W-1:0] pin_in,
  output logic              irq
);

  logic              rst_n_s;
  logic [PORT_W-1:0] sync_bus;
  logic [PORT_W-1:0] lvl_bus;
  logic [PORT_W-1:0] raw_pin;
  logic [PORT_W-1:0] raw_bus;
  logic [PORT_W-1:0] ack_bus;
  logic [PORT_W-1:0] chg_bus;
  port_cfg_t         cfg;

  gpio_irq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  gpio_irq_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .async_i (pin_in),
    .sync_o  (sync_bus)
  );

  assign lvl_bus = sync_bus & CONN_MASK;

  generate
    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
      gpio_irq_pin u_pin (
        .clk     (clk),
        .rst_n   (rst_n_s),
        .sense_i (cfg.sense[i]),
        .both_i  (cfg.both[i]),
        .pol_i   (cfg.pol[i]),
        .sync_i  (lvl_bus[i]),
        .ack_i   (ack_bus[i]),
        .chg_i   (chg_bus[i]),
        .raw_o   (raw_pin[i])
      );
    end
  endgenerate

  assign raw_bus = raw_pin & CONN_MASK;

  gpio_irq_regs #(.CONN_MASK(CONN_MASK)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .raw_i     (raw_bus),
    .lvl_i     (lvl_bus),
    .cfg_o     (cfg),
    .ack_o     (ack_bus),
    .chg_o     (chg_bus)
  );

  assign irq = |(raw_bus & cfg.mask);

  AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((raw_bus & cfg.mask) == '0) |-> !irq); // R7

  AST_ABSENT_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((raw_bus | cfg.mask | cfg.sense) & ~CONN_MASK) == '0); // R9

endmodule

// File: tb/gpio_irq_port_test.sv
module gpio_irq_port_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in;
  logic       irq;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  localparam logic [2:0] A_SENSE = 3'd0, A_BOTH = 3'd1, A_POL = 3'd2, A_MASK = 3'd3,
                         A_RAW = 3'd4, A_MIS = 3'd5, A_ACK = 3'd6, A_LVL = 3'd7;

  always #4 clk = ~clk;

  gpio_irq_port uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .irq       (irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    do_reset();
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check(v == 8'h00, "R1 register zero", v, 0);
    end
    check(irq == 1'b0, "R1 irq low", irq, 0);
  endtask

  task automatic t_rise_timing();
    logic [7:0] v;
    do_reset();
    wr(A_POL, 8'h04);
    wr(A_MASK, 8'h04);
    rd(A_MASK, v);
    check(v == 8'h04, "R10 mask readback", v, 8'h04);
    @(negedge clk);
    bus_addr = A_RAW;
    pin_in[2] = 1'b1;
    @(negedge clk);
    check(bus_rdata == 8'h00, "R2 raw clear after edge 1", bus_rdata, 0);
    @(negedge clk);
    check(bus_rdata == 8'h00, "R2 raw clear after edge 2", bus_rdata, 0);
    bus_addr = A_LVL; #1;
    check(bus_rdata == 8'h04, "R2 level seen after edge 2", bus_rdata, 8'h04);
    bus_addr = A_RAW;
    @(negedge clk);
    check(bus_rdata == 8'h04, "R2 raw set after edge 3", bus_rdata, 8'h04);
    check(irq == 1'b1, "R7 irq on masked rise", irq, 1);
    wr(A_ACK, 8'h04);
    rd(A_RAW, v);
    check(v == 8'h00, "R5 ack clears", v, 0);
    pin_in[2] = 1'b0;
    settle();
    rd(A_RAW, v);
    check(v == 8'h00, "R3 falling ignored when polarity high", v, 0);
    check(irq == 1'b0, "R7 irq low after ack", irq, 0);
  endtask

  task automatic t_falling();
    logic [7:0] v;
    do_reset();
    pin_in[0] = 1'b1;
    settle();
    rd(A_RAW, v);
    check(v == 8'h00, "R3 rising ignored when polarity low", v, 0);
    pin_in[0] = 1'b0;
    settle();
    rd(A_RAW, v);
    check(v == 8'h01, "R3 falling latches", v, 8'h01);
    check(irq == 1'b0, "R7 masked pin keeps irq low", irq, 0);
    rd(A_MIS, v);
    check(v == 8'h00, "R7 masked status zero under mask", v, 0);
  endtask

  task automatic t_both_and_race();
    logic [7:0] v;
    do_reset();
    wr(A_BOTH, 8'h08);
    wr(A_POL, 8'h08);
    pin_in[3] = 1'b1;
    settle();
    rd(A_RAW, v);
    check(v == 8'h08, "R4 rise latches in both mode", v, 8'h08);
    wr(A_ACK, 8'h08);
    pin_in[3] = 1'b0;
    settle();
    rd(A_RAW, v);
    check(v == 8'h08, "R4 fall latches despite polarity high", v, 8'h08);
    @(negedge clk);
    pin_in[3] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_addr = A_ACK; bus_wdata = 8'h08; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(A_RAW, v);
    check(v == 8'h08, "R5 edge wins over same-cycle ack", v, 8'h08);
    settle();
    rd(A_RAW, v);
    check(v == 8'h08, "R5 status sticky", v, 8'h08);
    wr(A_ACK, 8'h08);
    rd(A_RAW, v);
    check(v == 8'h00, "R5 later ack clears", v, 0);
  endtask

  task automatic t_level();
    logic [7:0] v;
    do_reset();
    wr(A_SENSE, 8'h10);
    wr(A_POL, 8'h10);
    wr(A_MASK, 8'h10);
    rd(A_RAW, v);
    check(v == 8'h00, "R6 low pin no match", v, 0);
    @(negedge clk);
    bus_addr = A_RAW;
    pin_in[4] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(bus_rdata == 8'h10, "R6 level follows after edge 2", bus_rdata, 8'h10);
    check(irq == 1'b1, "R7 level irq", irq, 1);
    wr(A_ACK, 8'h10);
    rd(A_RAW, v);
    check(v == 8'h10, "R6 ack ignored in level mode", v, 8'h10);
    pin_in[4] = 1'b0;
    settle();
    rd(A_RAW, v);
    check(v == 8'h00, "R6 not latched", v, 0);
    check(irq == 1'b0, "R6 irq drops with level", irq, 0);
    wr(A_POL, 8'h00);
    rd(A_RAW, v);
    check(v == 8'h10, "R6 low polarity matches low pin", v, 8'h10);
  endtask

  task automatic t_cfg_change();
    logic [7:0] v;
    do_reset();
    wr(A_POL, 8'h60);
    pin_in[5] = 1'b1; pin_in[6] = 1'b1;
    settle();
    rd(A_RAW, v);
    check(v == 8'h60, "R8 both pending", v, 8'h60);
    wr(A_POL, 8'h40);
    rd(A_RAW, v);
    check(v == 8'h40, "R8 changed pin cleared, other kept", v, 8'h40);
    wr(A_POL, 8'h40);
    rd(A_RAW, v);
    check(v == 8'h40, "R8 unchanged write keeps status", v, 8'h40);
    wr(A_BOTH, 8'h40);
    rd(A_RAW, v);
    check(v == 8'h00, "R8 both-edge change clears", v, 0);
  endtask

  task automatic t_mask();
    logic [7:0] v;
    do_reset();
    wr(A_BOTH, 8'h07);
    pin_in[2:0] = 3'b111;
    settle();
    wr(A_MASK, 8'h05);
    rd(A_MIS, v);
    check(v == 8'h05, "R7 masked status", v, 8'h05);
    check(irq == 1'b1, "R7 irq any masked", irq, 1);
    wr(A_MASK, 8'h08);
    rd(A_MIS, v);
    check(v == 8'h00, "R7 disjoint mask", v, 0);
    check(irq == 1'b0, "R7 irq none masked", irq, 0);
    rd(A_BOTH, v);
    check(v == 8'h07, "R10 both readback", v, 8'h07);
  endtask

  task automatic t_absent();
    logic [7:0] v;
    do_reset();
    wr(A_MASK, 8'hFF);
    wr(A_BOTH, 8'hFF);
    wr(A_SENSE, 8'h80);
    rd(A_MASK, v);
    check(v == 8'h7F, "R9 mask bit7 ignored", v, 8'h7F);
    rd(A_SENSE, v);
    check(v == 8'h00, "R9 sense bit7 ignored", v, 0);
    pin_in[7] = 1'b1;
    settle();
    rd(A_LVL, v);
    check(v == 8'h00, "R9 level bit7 zero", v, 0);
    rd(A_RAW, v);
    check(v == 8'h00, "R9 no raw from absent pin", v, 0);
    check(irq == 1'b0, "R9 no irq from absent pin", irq, 0);
  endtask

  initial begin
    t_reset();
    t_rise_timing();
    t_falling();
    t_both_and_race();
    t_level();
    t_cfg_change();
    t_mask();
    t_absent();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule